// File: doc/BRIEF.md
# Parallel SAR Converter Sampling Controller

This block is a synchronous host-side sequencer for a 12-bit successive-approximation converter that delivers its result on a parallel bus. A one-cycle sample request makes it drop the active-low convert-start strobe. It then follows the converter's busy line through a rise and a fall and opens the bus with active-low chip select and read. It captures the word on the edge that ends the read and presents it with a one-cycle valid pulse. A sample request never waits on the host: requests are remembered until the converter can legally start again.

Every analog timing limit is a parameter in nanoseconds or microseconds. Each is turned into a whole number of clock cycles from `CLK_PERIOD_NS`, rounding upward. These limits are the convert pulse width, the read pulse and data access time, the bus release plus quiet time, the track/hold acquisition time, the partial and full sleep wake-up times and the busy timeout. One hold-off counter enforces the post-read gap, the wake-up delay after reset, after a change of sleep depth, and after each conversion when auto-sleep is enabled. The busy input passes through a configurable synchronizer; `BUSY_SYNC_STAGES = 0` selects a direct connection.

Top module: `adc_sample_ctrl`

## Requirements
- R1: During reset `adc_convst_n`, `adc_cs_n` and `adc_rd_n` are high, and `result_valid` and `timeout_err` are low. After reset the full-sleep wake-up wait (WF cycles) is pending, so the first convert-start falls no earlier than WF and no later than WF+2 cycles after reset release.
- R2: A convert-start pulse holds `adc_convst_n` low for exactly CV = ceil(convert pulse ns / clock ns) cycles. It never overlaps chip select.
- R3: `adc_rd_n` and `adc_cs_n` fall together. They fall only while `adc_busy` is low, and only after busy was seen high for the current conversion. `adc_rd_n` is never low while `adc_cs_n` is high.
- R4: Read and chip select stay low for exactly RD = ceil(max(read pulse, access time) / clock) cycles and rise together.
- R5: `result_data` equals the value on `adc_data` just before the edge on which `adc_rd_n` rises. `result_valid` is high for exactly the one cycle that follows that edge.
- R6: When a request is waiting, the next convert-start falls exactly GAP = ceil(max(relinquish + quiet, acquisition) / clock) cycles after `adc_rd_n` rises. It never falls sooner.
- R7: Requests that arrive during a conversion or a wait are held and serviced once the wait ends. Several such requests merge into one conversion, and none is lost.
- R8: With `sleep_en` high at the end of a read, the next convert-start falls exactly WP cycles (partial, `sleep_full`=0) or WF cycles (full, `sleep_full`=1) after `adc_rd_n` rises, where WP and WF are the ceil-converted wake-up times.
- R9: A change of `sleep_full` holds off any convert-start for the wake-up time of the newly chosen depth. A request made in the same cycle starts between that wait and that wait plus 2 cycles after the change.
- R10: If busy does not rise, or does not fall, within TO cycles of its wait starting, `timeout_err` pulses for one cycle. The strobes stay inactive, no read takes place and no `result_valid` follows. With a busy that never rises, the pulse comes exactly TO cycles after `adc_convst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_req | input | 1 | One-cycle request for a conversion |
| sleep_en | input | 1 | Converter enters sleep after each conversion |
| sleep_full | input | 1 | Sleep depth: 1 full, 0 partial |
| adc_busy | input | 1 | Converter busy flag |
| adc_data | input | DATA_W | Converter parallel data bus |
| adc_convst_n | output | 1 | Convert-start strobe, active low |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| result_valid | output | 1 | One-cycle pulse marking a new result |
| result_data | output | DATA_W | Last captured conversion word |
| timeout_err | output | 1 | One-cycle pulse on a busy timeout |

## Verification
A wrong sequencer state shows up on the three strobes within one cycle. Read can open while busy is high, chip select can overlap the convert pulse, or a strobe width comes out one cycle off. A faulty hold-off count shows only at the next convert-start, as a gap shorter or longer than GAP, WP or WF cycles after the read ends. A lost or duplicated pending request changes the number of convert pulses seen over the following few hundred cycles. A wrong capture edge shows on `result_data` in the cycle of `result_valid`, because the bench drives the inverted word whenever the bus is not being read.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CONV,
      ST_WAIT_HI,
      ST_WAIT_LO,
      ST_READ
   } seq_state_t;

   // Round a time in ns up to whole clock cycles, never below one cycle.
   function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
      int unsigned c;
      c = (ns + per - 1) / per;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= (sr << 1) | STAGES'(d);
         end
         assign q = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/adc_holdoff.sv
module adc_holdoff #(
   parameter int unsigned HOLD_W     = 15,
   parameter int unsigned GAP_CYC    = 6,
   parameter int unsigned WAKE_P_CYC = 1000,
   parameter int unsigned WAKE_F_CYC = 25000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cycle_end,
   input  logic sleep_en,
   input  logic sleep_full,
   output logic clear
);
   localparam logic [HOLD_W-1:0] GAP_LD = HOLD_W'(GAP_CYC - 1);
   localparam logic [HOLD_W-1:0] WP_LD  = HOLD_W'(WAKE_P_CYC - 1);
   localparam logic [HOLD_W-1:0] WF_LD  = HOLD_W'(WAKE_F_CYC - 1);

   logic [HOLD_W-1:0] cnt, dec, wake_ld, arm_cyc, arm_mode, nxt;
   logic              full_q, mode_chg;

   always_comb begin
      wake_ld  = sleep_full ? WF_LD : WP_LD;
      mode_chg = (full_q != sleep_full);
      dec      = (cnt != '0) ? cnt - 1'b1 : '0;
      arm_cyc  = '0;
      if (cycle_end) begin
         arm_cyc = GAP_LD;
         if (sleep_en && (wake_ld > GAP_LD)) arm_cyc = wake_ld;
      end
      arm_mode = mode_chg ? wake_ld : '0;
      nxt = dec;
      if (arm_cyc > nxt)  nxt = arm_cyc;
      if (arm_mode > nxt) nxt = arm_mode;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= HOLD_W'(WAKE_F_CYC);
         full_q <= 1'b0;
      end else begin
         cnt    <= nxt;
         full_q <= sleep_full;
      end
   end

   assign clear = (cnt == '0) && !mode_chg;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_ctl_pkg::*;
#(
   parameter int unsigned CONV_CYC = 1,
   parameter int unsigned RD_CYC   = 1,
   parameter int unsigned TMO_CYC  = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sample_req,
   input  logic start_ok,
   input  logic busy_s,
   output logic convst_n,
   output logic cs_n,
   output logic rd_n,
   output logic capture,
   output logic cycle_end,
   output logic tmo_err
);
   localparam int unsigned CNT_W = $clog2(umax(CONV_CYC, RD_CYC) + 1);
   localparam int unsigned TMO_W = $clog2(TMO_CYC + 1);

   seq_state_t       state;
   logic [CNT_W-1:0] cnt;
   logic [TMO_W-1:0] tmo;
   logic             pend, start, tmo_fire;

   always_comb begin
      start    = (state == ST_IDLE) && (pend || sample_req) && start_ok;
      capture  = (state == ST_READ) && (cnt == '0);
      tmo_fire = (tmo == '0) &&
                 (((state == ST_WAIT_HI) && !busy_s) || ((state == ST_WAIT_LO) && busy_s));
      cycle_end = capture || tmo_fire;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         convst_n <= 1'b1;
         cs_n     <= 1'b1;
         rd_n     <= 1'b1;
         cnt      <= '0;
         tmo      <= '0;
         pend     <= 1'b0;
         tmo_err  <= 1'b0;
      end else begin
         tmo_err <= tmo_fire;
         pend    <= (pend || sample_req) && !start;
         case (state)
            ST_IDLE: if (start) begin
               state    <= ST_CONV;
               convst_n <= 1'b0;
               cnt      <= CNT_W'(CONV_CYC - 1);
            end
            ST_CONV: if (cnt == '0) begin
               convst_n <= 1'b1;
               state    <= ST_WAIT_HI;
               tmo      <= TMO_W'(TMO_CYC - 1);
            end else begin
               cnt <= cnt - 1'b1;
            end
            ST_WAIT_HI: if (busy_s) begin
               state <= ST_WAIT_LO;
               tmo   <= TMO_W'(TMO_CYC - 1);
            end else if (tmo_fire) begin
               state <= ST_IDLE;
            end else begin
               tmo <= tmo - 1'b1;
            end
            ST_WAIT_LO: if (!busy_s) begin
               state <= ST_READ;
               cs_n  <= 1'b0;
               rd_n  <= 1'b0;
               cnt   <= CNT_W'(RD_CYC - 1);
            end else if (tmo_fire) begin
               state <= ST_IDLE;
            end else begin
               tmo <= tmo - 1'b1;
            end
            ST_READ: if (capture) begin
               cs_n  <= 1'b1;
               rd_n  <= 1'b1;
               state <= ST_IDLE;
            end else begin
               cnt <= cnt - 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
   parameter int unsigned DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] din,
   output logic              valid,
   output logic [DATA_W-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout  <= '0;
      end else begin
         valid <= capture;
         if (capture) dout <= din;
      end
   end
endmodule

// File: rtl/adc_sample_ctrl.sv
module adc_sample_ctrl
   import adc_ctl_pkg::*;
#(
   parameter int unsigned DATA_W           = 12,
   parameter int unsigned CLK_PERIOD_NS    = 20,
   parameter int unsigned CONV_PULSE_NS    = 10,
   parameter int unsigned RD_PULSE_NS      = 20,
   parameter int unsigned ACCESS_NS        = 15,
   parameter int unsigned RELINQ_NS        = 8,
   parameter int unsigned QUIET_NS         = 100,
   parameter int unsigned ACQ_NS           = 120,
   parameter int unsigned WAKE_PARTIAL_US  = 20,
   parameter int unsigned WAKE_FULL_US     = 500,
   parameter int unsigned BUSY_TIMEOUT_NS  = 2000,
   parameter int unsigned BUSY_SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_req,
   input  logic              sleep_en,
   input  logic              sleep_full,
   input  logic              adc_busy,
   input  logic [DATA_W-1:0] adc_data,
   output logic              adc_convst_n,
   output logic              adc_cs_n,
   output logic              adc_rd_n,
   output logic              result_valid,
   output logic [DATA_W-1:0] result_data,
   output logic              timeout_err
);
   localparam int unsigned CONV_CYC   = ns2cyc(CONV_PULSE_NS, CLK_PERIOD_NS);
   localparam int unsigned RD_CYC     = ns2cyc(umax(RD_PULSE_NS, ACCESS_NS), CLK_PERIOD_NS);
   localparam int unsigned GAP_CYC    = ns2cyc(umax(RELINQ_NS + QUIET_NS, ACQ_NS), CLK_PERIOD_NS);
   localparam int unsigned WAKE_P_CYC = ns2cyc(WAKE_PARTIAL_US * 1000, CLK_PERIOD_NS);
   localparam int unsigned WAKE_F_CYC = ns2cyc(WAKE_FULL_US * 1000, CLK_PERIOD_NS);
   localparam int unsigned TMO_CYC    = ns2cyc(BUSY_TIMEOUT_NS, CLK_PERIOD_NS);
   localparam int unsigned HOLD_W     = $clog2(umax(umax(WAKE_F_CYC, WAKE_P_CYC), GAP_CYC) + 1);

   generate
      if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
         $error("adc_sample_ctrl: DATA_W out of range");
      end
      if (CLK_PERIOD_NS == 0) begin : g_bad_clk
         $error("adc_sample_ctrl: CLK_PERIOD_NS must be non-zero");
      end
      if (BUSY_SYNC_STAGES > 4) begin : g_bad_sync
         $error("adc_sample_ctrl: BUSY_SYNC_STAGES above 4");
      end
   endgenerate

   logic busy_s, start_ok, capture, cycle_end;

   adc_busy_sync #(.STAGES(BUSY_SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(adc_busy), .q(busy_s)
   );

   adc_holdoff #(
      .HOLD_W(HOLD_W), .GAP_CYC(GAP_CYC),
      .WAKE_P_CYC(WAKE_P_CYC), .WAKE_F_CYC(WAKE_F_CYC)
   ) u_hold (
      .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end),
      .sleep_en(sleep_en), .sleep_full(sleep_full), .clear(start_ok)
   );

   adc_seq_fsm #(.CONV_CYC(CONV_CYC), .RD_CYC(RD_CYC), .TMO_CYC(TMO_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .sample_req(sample_req), .start_ok(start_ok),
      .busy_s(busy_s), .convst_n(adc_convst_n), .cs_n(adc_cs_n), .rd_n(adc_rd_n),
      .capture(capture), .cycle_end(cycle_end), .tmo_err(timeout_err)
   );

   adc_result_reg #(.DATA_W(DATA_W)) u_res (
      .clk(clk), .rst_n(rst_n), .capture(capture), .din(adc_data),
      .valid(result_valid), .dout(result_data)
   );
endmodule

// File: rtl/adc_sample_ctrl_chk.sv
module adc_sample_ctrl_chk #(
   parameter int unsigned GAP_CYC = 6
) (
   input logic clk,
   input logic rst_n,
   input logic adc_convst_n,
   input logic adc_cs_n,
   input logic adc_rd_n,
   input logic adc_busy,
   input logic result_valid,
   input logic timeout_err
);
   localparam int unsigned SW = $clog2(GAP_CYC + 1);
   logic [SW-1:0] since_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           since_rd <= SW'(GAP_CYC);
      else if (!adc_rd_n)                   since_rd <= '0;
      else if (since_rd != SW'(GAP_CYC))    since_rd <= since_rd + 1'b1;
   end

   a_r2_convst_not_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_convst_n |-> adc_cs_n);
   a_r3_rd_within_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_rd_n |-> !adc_cs_n);
   a_r3_read_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_rd_n) |-> !adc_busy);
   a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);
   a_r5_valid_at_rd_release: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> $rose(adc_rd_n));
   a_r6_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_convst_n) |-> (since_rd >= SW'(GAP_CYC)));
   a_r10_err_releases: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> (adc_convst_n && adc_cs_n && adc_rd_n && !result_valid));
endmodule

bind adc_sample_ctrl adc_sample_ctrl_chk #(.GAP_CYC(GAP_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .adc_convst_n(adc_convst_n), .adc_cs_n(adc_cs_n),
   .adc_rd_n(adc_rd_n), .adc_busy(adc_busy), .result_valid(result_valid),
   .timeout_err(timeout_err)
);

// File: tb/sim_adc_sample_ctrl.sv
`timescale 1ns/1ps
module sim_adc_sample_ctrl;
   // Expected cycle counts at 20 ns, worked out from the requirements:
   localparam int CV   = 1;    // ceil(10/20) -> 1
   localparam int RD   = 1;    // ceil(max(20,15)/20)
   localparam int GAP  = 6;    // ceil(max(8+100,120)/20)
   localparam int WP   = 50;   // 1 us
   localparam int WF   = 100;  // 2 us
   localparam int TO   = 100;  // ceil(2000/20)
   localparam int BUSY_CYC = 40;
   // {value[12:1], sleep_en[0]}
   localparam logic [12:0] TBL [6] = '{
      {12'h000, 1'b0}, {12'hFFF, 1'b0}, {12'hA5A, 1'b1},
      {12'h5A5, 1'b0}, {12'h001, 1'b1}, {12'h800, 1'b0}};

   logic clk = 0, rst_n = 0, sample_req = 0, sleep_en = 0, sleep_full = 0, adc_busy = 0;
   logic [11:0] cur_val = 0, adc_data, result_data;
   logic adc_convst_n, adc_cs_n, adc_rd_n, result_valid, timeout_err;
   int cyc = 0, checks = 0, errors = 0, busy_mode = 0, bcnt = 0;
   int t_cf = 0, t_cr = 0, t_rf = 0, t_rr = 0, t_err = 0, rel_cyc = 0;
   int n_conv = 0, n_rd = 0, n_valid = 0, n_err = 0;
   logic p_conv = 1, p_rd = 1;
   logic [11:0] last_data = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   assign adc_data = (!adc_rd_n && !adc_cs_n) ? cur_val : ~cur_val;

   adc_sample_ctrl #(.WAKE_PARTIAL_US(1), .WAKE_FULL_US(2)) u0 (
      .clk(clk), .rst_n(rst_n), .sample_req(sample_req), .sleep_en(sleep_en),
      .sleep_full(sleep_full), .adc_busy(adc_busy), .adc_data(adc_data),
      .adc_convst_n(adc_convst_n), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
      .result_valid(result_valid), .result_data(result_data), .timeout_err(timeout_err));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Monitor and converter model, away from the active edge
   always @(negedge clk) begin
      if (p_conv && !adc_convst_n) begin
         t_cf = cyc; n_conv++;
         chk(adc_cs_n, "R2 convst overlaps cs", 0, 1);
         if (busy_mode != 1) begin adc_busy = 1; bcnt = BUSY_CYC; end
      end else if (adc_busy && busy_mode != 2) begin
         bcnt--;
         if (bcnt == 0) adc_busy = 0;
      end
      if (!p_conv && adc_convst_n) begin
         t_cr = cyc;
         chk(t_cr - t_cf == CV, "R2 convst width", t_cr - t_cf, CV);
      end
      if (p_rd && !adc_rd_n) begin
         t_rf = cyc; n_rd++;
         chk(!adc_cs_n && !adc_busy, "R3 read opened wrongly", {adc_cs_n, adc_busy}, 0);
      end
      if (!p_rd && adc_rd_n) begin
         t_rr = cyc;
         chk(t_rr - t_rf == RD && adc_cs_n, "R4 read width", t_rr - t_rf, RD);
      end
      if (result_valid) begin
         n_valid++; last_data = result_data;
         chk(cyc == t_rr, "R5 valid cycle", cyc, t_rr);
      end
      if (timeout_err) begin t_err = cyc; n_err++; end
      p_conv = adc_convst_n; p_rd = adc_rd_n;
   end

   task automatic step(input int n = 1);
      repeat (n) begin @(posedge clk); #2; end
   endtask
   task automatic pulse_req();
      sample_req = 1; step(); sample_req = 0;
   endtask
   task automatic wait_cnt(ref int c, input int target);
      for (int k = 0; k < 3000 && c < target; k++) step();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int nv, nc, gap;
      step(3);
      // R1: reset state
      chk(adc_convst_n && adc_cs_n && adc_rd_n && !result_valid && !timeout_err,
          "R1 reset levels", {adc_convst_n, adc_cs_n, adc_rd_n, result_valid, timeout_err}, 5'b11100);
      rst_n = 1; rel_cyc = cyc;
      pulse_req();                       // R7: held through the wake-up wait
      wait_cnt(n_conv, 1);
      chk(t_cf - rel_cyc >= WF && t_cf - rel_cyc <= WF + 2, "R1 first convert after wake", t_cf - rel_cyc, WF);
      wait_cnt(n_valid, 1);
      step(20);

      // Table of values and auto-sleep settings; R5, R6, R8
      cur_val = TBL[0][12:1]; sleep_en = TBL[0][0];
      pulse_req();
      for (int i = 0; i < 6; i++) begin
         nv = n_valid + 1;
         wait_cnt(n_valid, nv);
         chk(last_data == TBL[i][12:1], "R5 result data", last_data, TBL[i][12:1]);
         if (i < 5) begin
            nc = n_conv + 1;
            cur_val = TBL[i+1][12:1]; sleep_en = TBL[i+1][0];
            pulse_req();
            wait_cnt(n_conv, nc);
            gap = t_cf - t_rr;
            if (TBL[i][0]) chk(gap == WP, "R8 partial wake gap", gap, WP);
            else           chk(gap == GAP, "R6 quiet gap", gap, GAP);
         end
      end
      wait_cnt(n_valid, n_valid + 1);
      step(20);

      // R9: change depth to full, request at once
      sleep_en = 0; sleep_full = 1; rel_cyc = cyc; cur_val = 12'h3C3;
      pulse_req();
      wait_cnt(n_conv, n_conv + 1);
      chk(t_cf - rel_cyc >= WF && t_cf - rel_cyc <= WF + 2, "R9 full wake after change", t_cf - rel_cyc, WF);
      // R8: full sleep gap
      sleep_en = 1;
      wait_cnt(n_valid, n_valid + 1);
      chk(last_data == 12'h3C3, "R5 result data", last_data, 12'h3C3);
      nc = n_conv + 1;
      pulse_req();
      wait_cnt(n_conv, nc);
      chk(t_cf - t_rr == WF, "R8 full wake gap", t_cf - t_rr, WF);
      wait_cnt(n_valid, n_valid + 1);
      sleep_en = 0; sleep_full = 0; step(80);

      // R7: extra requests during a conversion merge into one
      nc = n_conv;
      pulse_req();
      wait_cnt(n_conv, nc + 1);
      step(5); pulse_req(); step(3); pulse_req();
      wait_cnt(n_conv, nc + 2);
      chk(t_cf - t_rr == GAP, "R7 pending serviced at gap", t_cf - t_rr, GAP);
      step(300);
      chk(n_conv == nc + 2, "R7 merged requests", n_conv - nc, 2);

      // R10: busy never rises
      busy_mode = 1; nv = n_valid; nc = n_rd;
      pulse_req();
      wait_cnt(n_err, 1);
      chk(n_err == 1 && t_err - t_cr == TO, "R10 timeout timing", t_err - t_cr, TO);
      step(2);
      chk(n_valid == nv && n_rd == nc, "R10 no read after timeout", n_rd - nc, 0);
      chk(adc_convst_n && adc_cs_n && adc_rd_n, "R10 strobes idle", {adc_convst_n, adc_cs_n, adc_rd_n}, 3'b111);

      // R10: busy stuck high
      step(20); busy_mode = 2;
      pulse_req();
      wait_cnt(n_err, 2);
      step(2);
      chk(n_err == 2 && n_valid == nv && n_rd == nc, "R10 stuck busy", n_err, 2);
      busy_mode = 0; step(60);

      // Recovery after errors
      cur_val = 12'h7E1;
      pulse_req();
      wait_cnt(n_valid, nv + 1);
      chk(last_data == 12'h7E1, "R5 result after recovery", last_data, 12'h7E1);
      step(5);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule